// File: doc/BRIEF.md
# Lockable GPIO Configuration Bank

This block holds the per-pin configuration words of one GPIO port: a pin enable word, two peripheral-select words and a lock word. Each word is reached through four neighbouring addresses. One replaces the whole word. The other three set, clear or flip only the bits written as one. Two bus ports reach the bank. One is the general peripheral bus. The other is a tightly coupled CPU bus.

The lock word protects pin configuration against stray software writes. A lock bit at one blocks peripheral-bus writes to that bit position in the three configuration words. The CPU-side port is never checked against the lock. Any port can set lock bits freely. A lock bit can be cleared only while a separate key sequencer reports a valid unlock for exactly the address being written. The bank takes that report as an input.

The port width `PIN_W` may be below 32. Bit positions above it do not exist: writes to them do nothing and they read as zero.

Top module: `gpio_lock_bank`

## Requirements
- R1: Byte address bits [ADDR_W-1:4] select the word: 0 enable, 1 peripheral select 0, 2 peripheral select 1, 3 lock. Bits [3:2] select the access kind: 0 replace, 1 set, 2 clear, 3 toggle. Bits [1:0] are ignored. Addresses at 0x40 and above change nothing and read as 0.
- R2: On the set, clear and toggle addresses, a bit written as zero leaves the stored bit as it was.
- R3: Bit positions at or above PIN_W cannot be written and always read as 0.
- R4: A peripheral-bus write leaves unchanged every configuration bit whose lock bit is 1. The other bits of the same write take effect.
- R5: A CPU-bus write to a configuration word modifies every addressed bit, whatever the lock holds.
- R6: Writes to the lock word may always turn lock bits on. A lock bit turns off only when unlock_ok is 1 and unlock_addr[ADDR_W-1:2] equals the write's address bits [ADDR_W-1:2]. This holds on both ports.
- R7: Reads at the set, clear and toggle addresses return 0.
- R8: If both ports write in the same cycle, the CPU-bus write is performed and the peripheral-bus write is dropped entirely.
- R9: After reset, all words are 0. A read returns its data on rdata one cycle after the request. The data is the value held before any write in that same cycle. rdata is 0 in a cycle that follows no read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pb_sel | input | 1 | Peripheral bus access request |
| pb_wr | input | 1 | Peripheral bus write (1) or read (0) |
| pb_addr | input | ADDR_W | Peripheral bus byte address |
| pb_wdata | input | 32 | Peripheral bus write data |
| pb_rdata | output | 32 | Peripheral bus read data, one cycle after request |
| lb_sel | input | 1 | CPU bus access request |
| lb_wr | input | 1 | CPU bus write (1) or read (0) |
| lb_addr | input | ADDR_W | CPU bus byte address |
| lb_wdata | input | 32 | CPU bus write data |
| lb_rdata | output | 32 | CPU bus read data, one cycle after request |
| unlock_ok | input | 1 | Key sequencer reports a valid unlock |
| unlock_addr | input | ADDR_W | Byte address the unlock was granted for |

## Verification
The bench builds the bank with PIN_W = 12 and ADDR_W = 8. With twelve pins, twenty upper bit positions are absent, so writing all ones exposes any leak into non-existent bits on every word. An 8-bit address leaves room for the unmapped range from 0x40 up, as well as for an unlock granted to a near-miss address. The bench drives both ports at once, with the lock partly set. This covers the cases where the lock and the port priority interact.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  typedef enum logic [1:0] {
    OP_RW  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TGL = 2'd3
  } alias_op_e;

  localparam int NUM_GRP  = 4;
  localparam int LOCK_GRP = 3;

  // new word value produced by one aliased access
  function automatic logic [31:0] apply_op(alias_op_e op, logic [31:0] old_v,
                                           logic [31:0] data);
    case (op)
      OP_RW:   return data;
      OP_SET:  return old_v | data;
      OP_CLR:  return old_v & ~data;
      default: return old_v ^ data;
    endcase
  endfunction

  // keep old value wherever the lock mask is one
  function automatic logic [31:0] merge_locked(logic [31:0] old_v, logic [31:0] new_v,
                                               logic [31:0] lock);
    return (new_v & ~lock) | (old_v & lock);
  endfunction

  // lock bits may only rise unless clearing is permitted
  function automatic logic [31:0] lock_next(logic [31:0] old_v, logic [31:0] new_v,
                                            logic permit);
    return permit ? new_v : (new_v | old_v);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_lock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [1:0]        grp,
  output alias_op_e         op
);
  localparam int GRP_LSB = 4;
  localparam int TOP_LSB = GRP_LSB + 2;

  generate
    if (ADDR_W > TOP_LSB) begin : g_wide
      assign hit = (addr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign grp = addr[GRP_LSB+1:GRP_LSB];
  assign op  = alias_op_e'(addr[3:2]);
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_lock_pkg::*;
#(
  parameter int PIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  alias_op_e        op,
  input  logic [PIN_W-1:0] wdata,
  input  logic             honour_lock,
  input  logic [PIN_W-1:0] lock,
  output logic [PIN_W-1:0] q
);
  logic [31:0]      raw_next;
  logic [31:0]      guarded;
  logic [PIN_W-1:0] q_next;

  assign raw_next = apply_op(op, 32'(q), 32'(wdata));
  assign guarded  = honour_lock ? merge_locked(32'(q), raw_next, 32'(lock)) : raw_next;
  assign q_next   = guarded[PIN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_next;
  end

  // R4: locked bits keep their value across a peripheral-bus write
  a_r4_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && honour_lock) |=> ((q & $past(lock)) == ($past(q) & $past(lock))));

  // R2: a word that is not written does not move
  a_r2_idle_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/gpio_lock_reg.sv
module gpio_lock_reg
  import gpio_lock_pkg::*;
#(
  parameter int PIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  alias_op_e        op,
  input  logic [PIN_W-1:0] wdata,
  input  logic             permit,
  output logic [PIN_W-1:0] q
);
  logic [31:0] candidate;
  logic [31:0] filtered;

  assign candidate = apply_op(op, 32'(q), 32'(wdata));
  assign filtered  = lock_next(32'(q), candidate, permit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= filtered[PIN_W-1:0];
  end

  // R6: no lock bit falls without an unlock grant
  a_r6_no_clear_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !permit) |=> ((q & $past(q)) == $past(q)));

  // R6: a set access always raises the written bits
  a_r6_set_always_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_lock_pkg::*;
#(
  parameter int PIN_W  = 20,
  parameter int ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sel,
  input  logic                            wr,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_GRP-1:0][PIN_W-1:0]   words,
  output logic [31:0]                     rdata
);
  logic      hit;
  logic [1:0] grp;
  alias_op_e op;
  logic      rd_req;
  logic [31:0] rd_val;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .hit(hit), .grp(grp), .op(op)
  );

  assign rd_req = sel && !wr;
  assign rd_val = (rd_req && hit && op == OP_RW) ? 32'(words[grp]) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_val;
  end

  // R7: alias addresses read back as zero
  a_r7_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && op != OP_RW) |=> (rdata == 32'd0));

  // R9: nothing appears without a read request
  a_r9_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (rdata == 32'd0));

  generate
    if (PIN_W < 32) begin : g_upper
      // R3: absent pins never show up on the read data
      a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rdata[31:PIN_W] == '0));
    end
  endgenerate
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpio_lock_pkg::*;
#(
  parameter int PIN_W  = 20,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_sel,
  input  logic              pb_wr,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [31:0]       pb_wdata,
  output logic [31:0]       pb_rdata,
  input  logic              lb_sel,
  input  logic              lb_wr,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [31:0]       lb_wdata,
  output logic [31:0]       lb_rdata,
  input  logic              unlock_ok,
  input  logic [ADDR_W-1:0] unlock_addr
);
  // named internal events
  logic              lb_go;
  logic              pb_go;
  logic              w_any;
  logic [ADDR_W-1:0] w_addr;
  logic [PIN_W-1:0]  w_data;
  logic              w_hit;
  logic [1:0]        w_grp;
  alias_op_e         w_op;
  logic              clr_permit;

  logic [NUM_GRP-1:0][PIN_W-1:0] words;
  logic [PIN_W-1:0]              lock_q;

  // CPU bus wins any collision; the peripheral write is dropped
  assign lb_go  = lb_sel && lb_wr;
  assign pb_go  = pb_sel && pb_wr && !lb_go;
  assign w_any  = lb_go || pb_go;
  assign w_addr = lb_go ? lb_addr : pb_addr;
  assign w_data = lb_go ? lb_wdata[PIN_W-1:0] : pb_wdata[PIN_W-1:0];

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_wdec (
    .addr(w_addr), .hit(w_hit), .grp(w_grp), .op(w_op)
  );

  assign clr_permit = unlock_ok && (unlock_addr[ADDR_W-1:2] == w_addr[ADDR_W-1:2]);

  genvar g;
  generate
    for (g = 0; g < LOCK_GRP; g++) begin : g_cfg
      gpio_cfg_reg #(.PIN_W(PIN_W)) u_word (
        .clk(clk), .rst_n(rst_n),
        .wr_en(w_any && w_hit && w_grp == 2'(g)),
        .op(w_op), .wdata(w_data),
        .honour_lock(pb_go), .lock(lock_q),
        .q(words[g])
      );
    end
  endgenerate

  gpio_lock_reg #(.PIN_W(PIN_W)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .wr_en(w_any && w_hit && w_grp == 2'(LOCK_GRP)),
    .op(w_op), .wdata(w_data), .permit(clr_permit),
    .q(lock_q)
  );
  assign words[LOCK_GRP] = lock_q;

  gpio_read_port #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_pb_rd (
    .clk(clk), .rst_n(rst_n), .sel(pb_sel), .wr(pb_wr), .addr(pb_addr),
    .words(words), .rdata(pb_rdata)
  );

  gpio_read_port #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_lb_rd (
    .clk(clk), .rst_n(rst_n), .sel(lb_sel), .wr(lb_wr), .addr(lb_addr),
    .words(words), .rdata(lb_rdata)
  );

  // R5: a CPU-bus replace of the enable word lands whole, lock or not
  a_r5_lb_replace_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_sel && lb_wr && lb_addr == '0) |=> (words[0] == $past(lb_wdata[PIN_W-1:0])));

  // R8: a colliding peripheral write cannot reach a word the CPU bus left alone
  a_r8_pb_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_go && pb_sel && pb_wr && lb_addr[ADDR_W-1:4] != 0 && pb_addr[ADDR_W-1:4] == 0)
      |=> $stable(words[0]));
endmodule

// File: tb/gpio_lock_bank_test.sv
module gpio_lock_bank_test;
  localparam int PW = 12;
  localparam int AW = 8;
  localparam int MASK = (1 << PW) - 1;

  logic clk = 0, rst_n = 0;
  logic pb_sel = 0, pb_wr = 0, lb_sel = 0, lb_wr = 0, unlock_ok = 0;
  logic [AW-1:0] pb_addr = 0, lb_addr = 0, unlock_addr = 0;
  logic [31:0] pb_wdata = 0, lb_wdata = 0;
  logic [31:0] pb_rdata, lb_rdata;

  int total = 0, bad = 0;
  int model [4];
  int exp_pb = 0, exp_lb = 0;
  string exp_tag = "R9 reset";

  always #4 clk = ~clk;

  gpio_lock_bank #(.PIN_W(PW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .pb_sel(pb_sel), .pb_wr(pb_wr), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
    .lb_sel(lb_sel), .lb_wr(lb_wr), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
    .unlock_ok(unlock_ok), .unlock_addr(unlock_addr)
  );

  function automatic int read_model(int a);
    if (a >= 'h40 || ((a >> 2) & 3) != 0) return 0;
    return model[a >> 4];
  endfunction

  function automatic void write_model(bit from_pb, int a, int d, bit ok, int ua);
    int g, op, old, nv;
    if (a >= 'h40) return;
    g = a >> 4; op = (a >> 2) & 3; old = model[g]; d = d & MASK;
    for (int b = 0; b < PW; b++) begin
      bit o = old[b], w = d[b], n;
      n = (op == 0) ? w : (op == 1) ? (o | w) : (op == 2) ? (o & !w) : (o ^ w);
      if (g < 3 && from_pb && model[3][b]) n = o;
      if (g == 3 && !(ok && (ua >> 2) == (a >> 2)) && o) n = 1;
      nv[b] = n;
    end
    model[g] = nv & MASK;
  endfunction

  task automatic compare();
    total += 2;
    if (pb_rdata !== 32'(exp_pb)) begin
      bad++;
      $display("FAIL %s pb_rdata actual=%h expected=%h", exp_tag, pb_rdata, exp_pb);
    end
    if (lb_rdata !== 32'(exp_lb)) begin
      bad++;
      $display("FAIL %s lb_rdata actual=%h expected=%h", exp_tag, lb_rdata, exp_lb);
    end
  endtask

  // one bus cycle: check previous results, drive, advance the model
  task automatic step(string tag, bit ps, bit pw, int pa, int pd,
                      bit ls, bit lw, int la, int ld, bit ok = 0, int ua = 0);
    @(negedge clk);
    compare();
    pb_sel = ps; pb_wr = pw; pb_addr = AW'(pa); pb_wdata = pd;
    lb_sel = ls; lb_wr = lw; lb_addr = AW'(la); lb_wdata = ld;
    unlock_ok = ok; unlock_addr = AW'(ua);
    exp_pb = (ps && !pw) ? read_model(pa) : 0;
    exp_lb = (ls && !lw) ? read_model(la) : 0;
    exp_tag = tag;
    if (ls && lw) write_model(0, la, ld, ok, ua);
    else if (ps && pw) write_model(1, pa, pd, ok, ua);
  endtask

  task automatic pbw(string t, int a, int d, bit ok = 0, int ua = 0);
    step(t, 1, 1, a, d, 0, 0, 0, 0, ok, ua);
  endtask
  task automatic lbw(string t, int a, int d, bit ok = 0, int ua = 0);
    step(t, 0, 0, 0, 0, 1, 1, a, d, ok, ua);
  endtask
  task automatic rd(string t, int a);
    step(t, 1, 0, a, 0, 1, 0, a, 0);
  endtask
  task automatic rd_all(string t);
    for (int g = 0; g < 4; g++) rd(t, g * 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R9 reset state, R1 map, R7 aliases
    for (int a = 0; a < 'h40; a += 4) rd("R9 R7 reset and aliases", a);
    rd("R1 unmapped read", 'h44);
    // R3 upper bits absent
    pbw("R3 wide write", 'h00, 32'hFFFF_FFFF);
    rd("R3 upper bits read 0", 'h00);
    rd("R7 set alias reads 0", 'h04);
    // R2 aliases on peripheral select 0
    pbw("R2 replace", 'h10, 'h5A5);
    pbw("R2 set", 'h14, 'h00F);
    rd("R2 after set", 'h10);
    pbw("R2 clear", 'h18, 'h0A0);
    rd("R2 after clear", 'h10);
    pbw("R2 toggle", 'h1C, 'hF0F);
    rd("R2 after toggle", 'h10);
    // R1 unmapped write and byte-offset bits
    pbw("R1 unmapped write", 'h50, 'hFFF);
    pbw("R1 low bits ignored", 'h23, 'h333);
    rd_all("R1 map after writes");
    // R6/R4 lock part of the port
    pbw("R6 set lock", 'h34, 'h0F0);
    rd("R6 lock read", 'h30);
    pbw("R4 locked replace", 'h00, 'h000);
    rd("R4 locked bits kept", 'h00);
    pbw("R4 locked set", 'h24, 'hFFF);
    pbw("R4 locked toggle", 'h1C, 'hFFF);
    rd_all("R4 after locked writes");
    // R5 CPU bus ignores lock
    lbw("R5 cpu replace", 'h00, 'h000);
    lbw("R5 cpu clear", 'h28, 'hFFF);
    rd_all("R5 after cpu writes");
    // R6 clearing lock
    pbw("R6 clear no grant", 'h38, 'hFFF);
    lbw("R6 cpu clear no grant", 'h30, 'h000);
    pbw("R6 clear wrong addr", 'h38, 'h0F0, 1, 'h30);
    rd("R6 lock still set", 'h30);
    pbw("R6 replace with grant", 'h30, 'h00C, 1, 'h30);
    rd("R6 lock replaced", 'h30);
    pbw("R6 toggle no grant", 'h3C, 'h00F);
    rd("R6 toggle only raised", 'h30);
    lbw("R6 clear with grant", 'h38, 'hFFF, 1, 'h3A);
    rd("R6 lock cleared", 'h30);
    // R8 collisions
    step("R8 collide other word", 1, 1, 'h00, 'hABC, 1, 1, 'h10, 'h123);
    rd_all("R8 pb write dropped");
    step("R8 collide same word", 1, 1, 'h24, 'hFFF, 1, 1, 'h20, 'h001);
    rd_all("R8 same word cpu wins");
    // R9 read during write returns old value
    step("R9 read old value", 1, 0, 'h20, 0, 1, 1, 'h20, 'h777);
    step("R9 read new value", 1, 0, 'h20, 0, 1, 0, 'h20, 0);
    step("R9 idle read zero", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 idle again", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule